// File: doc/BRIEF.md
# Lazy Threshold Multi-Queue Trace Arbiter

This block merges words from several per-core trace queues onto a single output stream. The queues themselves live outside the block. Each queue reports its fill level, its head word and a valid flag. The arbiter answers with a one-cycle pop strobe for each word it forwards downstream. A queue competes for service only once its fill level has reached a threshold set for that queue. The output lane is then handed to the competing queue with the largest priority value.

Switching between queues costs bandwidth, so a granted queue keeps the lane for at least a configured number of transferred words. After that minimum the arbiter does not re-arbitrate on every cycle. It stays on the same queue until that queue falls below its threshold, runs empty, or a strictly more important queue is waiting. Every switch passes through one idle cycle. This gives the external queues time to publish the level that results from the last pop before the next decision is made.

Top module: `trace_merge_arb`

## Requirements
- R1: Queue i requests service only while its level is nonzero and at least `cfg_thresh[i]`. A queue whose level stays below its threshold is never granted.
- R2: When a grant is made, the winner is the requesting queue with the largest `cfg_prio` value. On equal values the lowest queue index wins.
- R3: A granted queue transfers at least the granularity value latched at grant time before the arbiter leaves it, unless the queue runs empty first.
- R4: When the granted queue's level reaches zero (including through its final pop), the grant ends immediately, even if the minimum has not been met.
- R5: Once the minimum is met, the grant continues until the queue's level after the current transfer is below its threshold, or until a queue with a strictly larger priority value is requesting. A lower- or equal-priority requester does not end the grant.
- R6: A word moves only in a cycle where `out_valid` and `out_ready` are both high. In that cycle exactly the granted queue's bit of `q_pop` is set, and no other bit. Only such transfers advance the granularity count.
- R7: While no queue is granted, `out_valid` is low and `q_pop` is all zeros.
- R8: `cfg_gran` is sampled in the cycle a grant is made. Changes during a grant take effect at the next grant.
- R9: `grant_active` is high throughout a grant and `grant_idx` holds the granted queue, stable for the whole grant. Between two grants there is at least one cycle with `grant_active` low.
- R10: After reset, `grant_active`, `out_valid` and `q_pop` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_level | input | NQ*OCCW | Fill level of each queue; queue i in bits [i*OCCW +: OCCW] |
| q_data | input | NQ*DW | Head word of each queue; queue i in bits [i*DW +: DW] |
| q_valid | input | NQ | Head word of queue i is present |
| q_pop | output | NQ | Pop strobe: queue i's head word was taken this cycle |
| out_data | output | DW | Merged output word |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the word |
| cfg_thresh | input | NQ*OCCW | Request threshold of each queue |
| cfg_prio | input | NQ*PRIO_W | Priority value of each queue; larger wins |
| cfg_gran | input | GW | Minimum words per grant |
| grant_idx | output | IW | Index of the granted queue |
| grant_active | output | 1 | A queue currently holds the grant |

## Verification
A queue whose level crosses its threshold at clock edge N is granted at edge N+1. Its head word is offered combinationally in that same cycle. A release decided at edge M leaves edge M+1 idle, so the next grant lands no earlier than edge M+2. The bench sidesteps these latencies in the data path. A scoreboard holds the expected word order for each scenario, and a monitor compares every accepted word, together with its grant index and pop strobe, at the falling edge of the cycle in which it moves. Checks that depend on state, such as the winner of an arbitration or a block that has gone idle, are taken several whole cycles after the stimulus, once both register stages have settled.

// File: rtl/tlq_pkg.sv
package tlq_pkg;
   typedef enum logic {
      ARB_IDLE  = 1'b0,
      ARB_SERVE = 1'b1
   } arb_state_e;
endpackage

// File: rtl/tlq_req.sv
module tlq_req #(
   parameter int NQ   = 4,
   parameter int OCCW = 5
) (
   input  logic [NQ*OCCW-1:0] level,
   input  logic [NQ*OCCW-1:0] thresh,
   output logic [NQ-1:0]      req
);
   for (genvar i = 0; i < NQ; i++) begin : g_req
      assign req[i] = (level[i*OCCW +: OCCW] != '0) &&
                      (level[i*OCCW +: OCCW] >= thresh[i*OCCW +: OCCW]);
   end
endmodule

// File: rtl/tlq_pick.sv
module tlq_pick #(
   parameter int NQ     = 4,
   parameter int PRIO_W = 2,
   parameter int IW     = 2
) (
   input  logic [NQ-1:0]        req,
   input  logic [NQ*PRIO_W-1:0] prio,
   output logic                 any,
   output logic [IW-1:0]        best_idx,
   output logic [PRIO_W-1:0]    best_prio
);
   always_comb begin
      any       = 1'b0;
      best_idx  = '0;
      best_prio = '0;
      for (int i = 0; i < NQ; i++) begin
         if (req[i] && (!any || prio[i*PRIO_W +: PRIO_W] > best_prio)) begin
            any       = 1'b1;
            best_idx  = IW'(i);
            best_prio = prio[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/tlq_mux.sv
module tlq_mux #(
   parameter int NQ = 4,
   parameter int DW = 16,
   parameter int IW = 2
) (
   input  logic [IW-1:0]    sel,
   input  logic [NQ*DW-1:0] data,
   input  logic [NQ-1:0]    valid,
   output logic [DW-1:0]    data_o,
   output logic             valid_o
);
   if ((1 << IW) == NQ) begin : g_indexed
      assign data_o  = data[sel*DW +: DW];
      assign valid_o = valid[sel];
   end else begin : g_andor
      always_comb begin
         data_o  = '0;
         valid_o = 1'b0;
         for (int i = 0; i < NQ; i++) begin
            if (sel == IW'(i)) begin
               data_o  = data[i*DW +: DW];
               valid_o = valid[i];
            end
         end
      end
   end
endmodule

// File: rtl/trace_merge_arb.sv
module trace_merge_arb
   import tlq_pkg::*;
#(
   parameter int NQ     = 4,
   parameter int DW     = 16,
   parameter int QDEPTH = 16,
   parameter int PRIO_W = 2,
   parameter int GW     = 8,
   localparam int OCCW  = $clog2(QDEPTH + 1),
   localparam int IW    = (NQ > 1) ? $clog2(NQ) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NQ*OCCW-1:0]   q_level,
   input  logic [NQ*DW-1:0]     q_data,
   input  logic [NQ-1:0]        q_valid,
   output logic [NQ-1:0]        q_pop,
   output logic [DW-1:0]        out_data,
   output logic                 out_valid,
   input  logic                 out_ready,
   input  logic [NQ*OCCW-1:0]   cfg_thresh,
   input  logic [NQ*PRIO_W-1:0] cfg_prio,
   input  logic [GW-1:0]        cfg_gran,
   output logic [IW-1:0]        grant_idx,
   output logic                 grant_active
);
   if (NQ < 2 || DW < 1 || QDEPTH < 1 || PRIO_W < 1 || GW < 1) begin : g_bad_cfg
      $error("trace_merge_arb: NQ must be >= 2 and all widths >= 1");
   end

   arb_state_e        st;
   logic [IW-1:0]     cur;
   logic [GW-1:0]     served, gran_l, served_nxt;
   logic [NQ-1:0]     req;
   logic              any_req;
   logic [IW-1:0]     best_idx;
   logic [PRIO_W-1:0] best_prio, cur_prio;
   logic [OCCW-1:0]   cur_lvl, cur_thr, lvl_after, fire_w;
   logic [DW-1:0]     mux_data;
   logic              mux_valid, fire, hp_wait, empty_rel, lazy_rel, release_now;

   tlq_req #(.NQ(NQ), .OCCW(OCCW)) u_req (
      .level (q_level),
      .thresh(cfg_thresh),
      .req   (req)
   );

   tlq_pick #(.NQ(NQ), .PRIO_W(PRIO_W), .IW(IW)) u_pick (
      .req      (req),
      .prio     (cfg_prio),
      .any      (any_req),
      .best_idx (best_idx),
      .best_prio(best_prio)
   );

   tlq_mux #(.NQ(NQ), .DW(DW), .IW(IW)) u_mux (
      .sel    (cur),
      .data   (q_data),
      .valid  (q_valid),
      .data_o (mux_data),
      .valid_o(mux_valid)
   );

   always_comb begin
      cur_lvl  = '0;
      cur_thr  = '0;
      cur_prio = '0;
      for (int i = 0; i < NQ; i++) begin
         if (cur == IW'(i)) begin
            cur_lvl  = q_level[i*OCCW +: OCCW];
            cur_thr  = cfg_thresh[i*OCCW +: OCCW];
            cur_prio = cfg_prio[i*PRIO_W +: PRIO_W];
         end
      end
   end

   assign grant_active = (st == ARB_SERVE);
   assign grant_idx    = cur;
   assign out_valid    = grant_active && mux_valid;
   assign out_data     = mux_data;
   assign fire         = out_valid && out_ready;

   for (genvar i = 0; i < NQ; i++) begin : g_pop
      assign q_pop[i] = fire && (cur == IW'(i));
   end

   assign fire_w      = {{(OCCW-1){1'b0}}, fire};
   assign served_nxt  = (fire && served != '1) ? served + 1'b1 : served;
   assign lvl_after   = (cur_lvl > fire_w) ? cur_lvl - fire_w : '0;
   assign hp_wait     = any_req && (best_prio > cur_prio);
   assign empty_rel   = (cur_lvl <= fire_w);
   assign lazy_rel    = (served_nxt >= gran_l) && ((lvl_after < cur_thr) || hp_wait);
   assign release_now = empty_rel || lazy_rel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ARB_IDLE;
         cur    <= '0;
         served <= '0;
         gran_l <= '0;
      end else begin
         case (st)
            ARB_IDLE: begin
               if (any_req) begin
                  st     <= ARB_SERVE;
                  cur    <= best_idx;
                  served <= '0;
                  gran_l <= cfg_gran;
               end
            end
            default: begin
               if (release_now) begin
                  st <= ARB_IDLE;
               end else begin
                  served <= served_nxt;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/tlq_chk.sv
module tlq_chk #(
   parameter int NQ     = 4,
   parameter int QDEPTH = 16,
   parameter int GW     = 8,
   localparam int OCCW  = $clog2(QDEPTH + 1),
   localparam int IW    = (NQ > 1) ? $clog2(NQ) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NQ*OCCW-1:0]  q_level,
   input logic [NQ-1:0]       q_valid,
   input logic [NQ-1:0]       q_pop,
   input logic                out_valid,
   input logic                out_ready,
   input logic [NQ*OCCW-1:0]  cfg_thresh,
   input logic [GW-1:0]       cfg_gran,
   input logic [IW-1:0]       grant_idx,
   input logic                grant_active
);
   logic [GW-1:0]   cnt, gran_seen;
   logic [OCCW-1:0] lvl_g;
   logic [NQ-1:0]   was_eligible;
   logic            hit_empty, xfer;

   assign xfer = out_valid && out_ready;

   always_comb begin
      lvl_g = '0;
      for (int i = 0; i < NQ; i++) begin
         if (grant_idx == IW'(i)) lvl_g = q_level[i*OCCW +: OCCW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt          <= '0;
         gran_seen    <= '0;
         hit_empty    <= 1'b0;
         was_eligible <= '0;
      end else begin
         for (int i = 0; i < NQ; i++) begin
            was_eligible[i] <= (q_level[i*OCCW +: OCCW] != '0) &&
                               (q_level[i*OCCW +: OCCW] >= cfg_thresh[i*OCCW +: OCCW]);
         end
         if (!grant_active) begin
            cnt       <= '0;
            gran_seen <= cfg_gran;
            hit_empty <= 1'b0;
         end else begin
            if (xfer && cnt != '1) cnt <= cnt + 1'b1;
            hit_empty <= (lvl_g == '0) || (xfer && lvl_g == OCCW'(1));
         end
      end
   end

   assert_grant_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_active) |-> was_eligible[grant_idx]);

   assert_min_gran_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(grant_active) |-> (cnt >= gran_seen) || hit_empty);

   assert_pop_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(q_pop));

   assert_pop_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (q_pop != '0) |-> (out_valid && out_ready));

   assert_valid_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> q_valid[grant_idx]);

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_active |-> (!out_valid && q_pop == '0));

   assert_grant_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_active && $past(grant_active)) |-> $stable(grant_idx));
endmodule

bind trace_merge_arb tlq_chk #(.NQ(NQ), .QDEPTH(QDEPTH), .GW(GW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .q_level     (q_level),
   .q_valid     (q_valid),
   .q_pop       (q_pop),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .cfg_thresh  (cfg_thresh),
   .cfg_gran    (cfg_gran),
   .grant_idx   (grant_idx),
   .grant_active(grant_active)
);

// File: tb/trace_merge_arb_tb.sv
module trace_merge_arb_tb;
   localparam int NQ     = 4;
   localparam int DW     = 16;
   localparam int QDEPTH = 16;
   localparam int PRIO_W = 2;
   localparam int GW     = 8;
   localparam int OCCW   = $clog2(QDEPTH + 1);
   localparam int IW     = $clog2(NQ);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NQ*OCCW-1:0]   q_level = '0;
   logic [NQ*DW-1:0]     q_data = '0;
   logic [NQ-1:0]        q_valid = '0;
   logic [NQ-1:0]        q_pop;
   logic [DW-1:0]        out_data;
   logic                 out_valid;
   logic                 out_ready = 1'b0;
   logic [NQ*OCCW-1:0]   cfg_thresh = '0;
   logic [NQ*PRIO_W-1:0] cfg_prio = '0;
   logic [GW-1:0]        cfg_gran = '0;
   logic [IW-1:0]        grant_idx;
   logic                 grant_active;

   int n_tests = 0;
   int n_fail  = 0;
   int rdy_mode = 0;
   int add_n [NQ];
   int push_seq [NQ];
   int exp_seq [NQ];
   logic [DW-1:0] fifo [NQ][$];
   logic [DW-1:0] expq [$];
   string         tagq [$];

   always #5 clk = ~clk;

   trace_merge_arb #(.NQ(NQ), .DW(DW), .QDEPTH(QDEPTH), .PRIO_W(PRIO_W), .GW(GW)) u_dut (
      .clk(clk), .rst_n(rst_n), .q_level(q_level), .q_data(q_data), .q_valid(q_valid),
      .q_pop(q_pop), .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
      .cfg_thresh(cfg_thresh), .cfg_prio(cfg_prio), .cfg_gran(cfg_gran),
      .grant_idx(grant_idx), .grant_active(grant_active)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // queue model: the only process writing fifo and the q_* inputs
   always @(posedge clk) begin
      logic [NQ*OCCW-1:0] lv;
      logic [NQ*DW-1:0]   dv;
      logic [NQ-1:0]      vv;
      for (int i = 0; i < NQ; i++) begin
         if (q_pop[i] && fifo[i].size() > 0) void'(fifo[i].pop_front());
         for (int k = 0; k < add_n[i]; k++) begin
            fifo[i].push_back({4'(i), 12'(push_seq[i])});
            push_seq[i]++;
         end
         lv[i*OCCW +: OCCW] = OCCW'(fifo[i].size());
         dv[i*DW +: DW]     = (fifo[i].size() > 0) ? fifo[i][0] : '0;
         vv[i]              = (fifo[i].size() > 0);
      end
      q_level <= lv;
      q_data  <= dv;
      q_valid <= vv;
   end

   // ready driver
   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         #1;
         cyc++;
         case (rdy_mode)
            0:       out_ready = 1'b0;
            1:       out_ready = 1'b1;
            default: out_ready = (cyc % 3 != 1);
         endcase
      end
   end

   // monitor: pops the scoreboard on every accepted word
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
               check(1'b0, "R6", "unexpected word", int'(out_data), 0);
            end else begin
               logic [DW-1:0] e;
               string t;
               e = expq.pop_front();
               t = tagq.pop_front();
               check(out_data == e, t, "word order", int'(out_data), int'(e));
               check(grant_idx == IW'(e[15:12]), "R9", "grant index", int'(grant_idx), int'(e[15:12]));
               check(q_pop == NQ'(1 << e[15:12]), "R6", "pop strobe", int'(q_pop), 1 << e[15:12]);
            end
         end else if (out_valid) begin
            check(q_pop == '0, "R6", "no pop without ready", int'(q_pop), 0);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic push(input int q, input int n);
      add_n[q] = n;
   endtask

   task automatic commit();
      @(posedge clk);
      #1;
      for (int i = 0; i < NQ; i++) add_n[i] = 0;
   endtask

   task automatic expect_words(input int q, input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         expq.push_back({4'(q), 12'(exp_seq[q])});
         tagq.push_back(tag);
         exp_seq[q]++;
      end
   endtask

   task automatic set_thr(input int q, input int v);
      cfg_thresh[q*OCCW +: OCCW] = OCCW'(v);
   endtask

   task automatic set_prio(input int q, input int v);
      cfg_prio[q*PRIO_W +: PRIO_W] = PRIO_W'(v);
   endtask

   task automatic wait_grant(input int q, input string tag);
      bit seen = 1'b0;
      for (int k = 0; k < 20 && !seen; k++) begin
         @(negedge clk);
         if (grant_active && grant_idx == IW'(q)) seen = 1'b1;
      end
      check(seen, tag, "grant reached queue", int'(grant_idx), q);
      tick(1);
   endtask

   task automatic drain(input string tag);
      for (int k = 0; k < 400 && expq.size() > 0; k++) @(posedge clk);
      tick(4);
      check(expq.size() == 0, tag, "all expected words delivered", expq.size(), 0);
   endtask

   task automatic check_idle(input string tag);
      @(negedge clk);
      check(!grant_active, tag, "grant released", int'(grant_active), 0);
      check(!out_valid, tag, "output idle", int'(out_valid), 0);
      tick(1);
   endtask

   initial begin
      for (int i = 0; i < NQ; i++) begin
         add_n[i] = 0; push_seq[i] = 0; exp_seq[i] = 0;
      end
      for (int i = 0; i < NQ; i++) set_thr(i, 1);
      set_prio(0, 1); set_prio(1, 1); set_prio(2, 2); set_prio(3, 3);
      cfg_gran = 8'd8;
      tick(3);
      // R10: reset state
      check(!grant_active, "R10", "grant after reset", int'(grant_active), 0);
      check(!out_valid, "R10", "valid after reset", int'(out_valid), 0);
      check(q_pop == '0, "R10", "pop after reset", int'(q_pop), 0);
      rst_n = 1'b1;
      tick(2);

      // R4: single queue, 3 words under a granularity of 8
      rdy_mode = 1;
      push(2, 3); commit();
      expect_words(2, 3, "R4");
      drain("R4");
      check_idle("R7");

      // R1: below threshold no service; at threshold served
      set_thr(0, 4);
      push(0, 3); commit();
      tick(6);
      check_idle("R1");
      expect_words(0, 4, "R1");
      push(0, 1); commit();
      drain("R1");
      set_thr(0, 1);

      // R2: highest priority value wins
      rdy_mode = 0; tick(1);
      push(0, 8); push(3, 8); commit();
      tick(3);
      check(grant_active && grant_idx == 2'd3, "R2", "winner among q0/q3", int'(grant_idx), 3);
      expect_words(3, 8, "R2");
      expect_words(0, 8, "R2");
      rdy_mode = 1;
      drain("R2");

      // R2: tie goes to the lower index
      rdy_mode = 0; tick(1);
      push(1, 2); push(0, 2); commit();
      tick(3);
      check(grant_active && grant_idx == 2'd0, "R2", "tie winner", int'(grant_idx), 0);
      expect_words(0, 2, "R2");
      expect_words(1, 2, "R2");
      rdy_mode = 1;
      drain("R2");

      // R3 / R6: granularity 4 against a higher-priority arrival, with stalls
      rdy_mode = 0; cfg_gran = 8'd4; tick(1);
      push(0, 10); commit();
      wait_grant(0, "R3");
      push(3, 6); commit();
      expect_words(0, 4, "R3");
      expect_words(3, 6, "R3");
      expect_words(0, 6, "R6");
      rdy_mode = 2;
      drain("R3");

      // R5: lazy hold against a lower-priority requester, release below threshold
      rdy_mode = 0; cfg_gran = 8'd1; set_thr(1, 4); set_prio(2, 0); tick(1);
      push(1, 8); commit();
      wait_grant(1, "R5");
      push(2, 3); commit();
      expect_words(1, 5, "R5");
      expect_words(2, 3, "R5");
      rdy_mode = 1;
      drain("R5");
      check_idle("R5");
      set_thr(1, 1);
      expect_words(1, 3, "R1");
      drain("R1");

      // R8: granularity change during a grant applies only to the next grant
      rdy_mode = 0; cfg_gran = 8'd2; tick(1);
      push(0, 4); commit();
      wait_grant(0, "R8");
      cfg_gran = 8'd6;
      push(3, 4); commit();
      expect_words(0, 2, "R8");
      expect_words(3, 4, "R8");
      expect_words(0, 2, "R8");
      rdy_mode = 1;
      drain("R8");
      check_idle("R7");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule